// File: doc/BRIEF.md
# Selectable-Rate Watchdog Timer

This block is a small supervisory counter that watches whether software is still in control. A 4-bit up-counter advances on single-cycle enable pulses that come from a prescaler outside the block. The prescaler offers two taps: a fast tick at oscillator/1024 and a slow tick at oscillator/16384. Software keeps the counter from reaching its limit by strobing a kick input, which returns the count to zero. If the counter steps past its top value, the block raises a one-cycle request to reset the chip.

A rate bit chooses which tap drives the counter. Software sets and clears the bit through two strobes. Synchronous reset clears the bit, so the fast tap is in use after reset. A static option strap turns the whole function on or off. While the strap is low, the counter stays at zero and no reset request is raised.

With a 32 kHz oscillator and the fast tap, the shortest time from a kick to a reset request is 15 full tick periods, about 468.75 ms. All inputs are plain control strobes with no handshake. The request output is a registered pulse, and the chip's reset distribution consumes it directly.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count clears to zero, the rate bit selects the fast tap, and `wdt_rst_req` is low. After reset, only `tick_fast` advances the counter.
- R2: While the fast tap is selected, pulses on `tick_slow` do not change the count.
- R3: Counting from zero, the 16th selected tick raises `wdt_rst_req` during the one clock cycle that follows the edge that sampled that tick. The output is low again in the next cycle.
- R4: After an overflow the counter restarts from zero. The next request needs 16 further selected ticks.
- R5: A pulse on `rate_set` selects the slow tap (rate bit = 1). After that, `tick_fast` pulses do not change the count and `tick_slow` pulses advance it.
- R6: A pulse on `rate_clr` selects the fast tap (rate bit = 0). When `rate_set` and `rate_clr` are high in the same cycle, the clear wins.
- R7: A pulse on `kick` sets the count to zero. When a kick and a selected tick arrive in the same cycle, the kick takes priority and the count becomes zero.
- R8: While `en_strap` is 0, the count is held at zero and `wdt_rst_req` stays low. When the strap returns to 1, counting starts from zero.
- R9: A rate command takes effect on ticks from the cycle after the edge that registers it. A tick in the same cycle as the command is judged against the old selection. The count is kept across a rate change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_strap | input | 1 | Static option: 1 enables the watchdog |
| tick_fast | input | 1 | One-cycle enable pulse at oscillator/1024 |
| tick_slow | input | 1 | One-cycle enable pulse at oscillator/16384 |
| rate_set | input | 1 | Strobe: select the slow tap |
| rate_clr | input | 1 | Strobe: select the fast tap |
| kick | input | 1 | Strobe: clear the counter |
| wdt_rst_req | output | 1 | One-cycle chip-reset request on overflow |

## Verification
A tick, kick or strap change is sampled at one rising edge. Its effect on the count is complete at that edge, and `wdt_rst_req` is high for the whole cycle between that edge and the next one. A rate strobe changes the selection at its edge, so it governs ticks from the following cycle onward. The bench drives every stimulus on a falling edge and reads `wdt_rst_req` on the next falling edge, which falls inside the single cycle when a pulse can be present. To confirm that a pulse lasts only one cycle, the bench reads the output again one falling edge later. Counts are inferred at the ports by how many ticks it takes to reach the request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Tap selection held by the rate register.
  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } wdog_rate_e;
endpackage

// File: rtl/wdog_rate_sel.sv
module wdog_rate_sel
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rate_set,
  input  logic rate_clr,
  input  logic tick_fast,
  input  logic tick_slow,
  output logic tick_sel
);
  wdog_rate_e rate_q;

  // Clear has priority over set; reset lands on the fast tap.
  always_ff @(posedge clk) begin
    if (!rst_n)        rate_q <= RATE_FAST;
    else if (rate_clr) rate_q <= RATE_FAST;
    else if (rate_set) rate_q <= RATE_SLOW;
  end

  always_comb begin
    tick_sel = (rate_q == RATE_SLOW) ? tick_slow : tick_fast;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rate_clr |=> (rate_q == RATE_FAST)); // R6
  AST_SET_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_set && !rate_clr) |=> (rate_q == RATE_SLOW)); // R5
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_set && !rate_clr) |=> $stable(rate_q)); // R9
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic kick,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (!en || kick) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
      end
    end
  end

  assign ovf_o = ovf_q;

  AST_KICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0)); // R7
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !kick) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0)); // R4
  AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && !ovf_q)); // R8
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_strap,
  input  logic tick_fast,
  input  logic tick_slow,
  input  logic rate_set,
  input  logic rate_clr,
  input  logic kick,
  output logic wdt_rst_req
);
  logic tick_sel;

  wdog_rate_sel u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_set  (rate_set),
    .rate_clr  (rate_clr),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .tick_sel  (tick_sel)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_strap),
    .tick  (tick_sel),
    .kick  (kick),
    .ovf_o (wdt_rst_req)
  );

  AST_STRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_strap |=> !wdt_rst_req); // R8
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_strap = 1'b1;
  logic tick_fast = 1'b0, tick_slow = 1'b0;
  logic rate_set = 1'b0, rate_clr = 1'b0, kick = 1'b0;
  logic wdt_rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer uut (
    .clk(clk), .rst_n(rst_n), .en_strap(en_strap),
    .tick_fast(tick_fast), .tick_slow(tick_slow),
    .rate_set(rate_set), .rate_clr(rate_clr), .kick(kick),
    .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle of strobes, sample the request one cycle later.
  task automatic apply(input bit f, input bit s, input bit k,
                       input bit set, input bit clr, output bit seen);
    @(negedge clk);
    tick_fast = f; tick_slow = s; kick = k; rate_set = set; rate_clr = clr;
    @(negedge clk);
    seen = wdt_rst_req;
    tick_fast = 0; tick_slow = 0; kick = 0; rate_set = 0; rate_clr = 0;
  endtask

  // Apply n ticks; first = index of first pulse (0 = none), total = pulses.
  task automatic run_ticks(input int n, input bit slow, output int first, output int total);
    bit seen;
    first = 0; total = 0;
    for (int i = 1; i <= n; i++) begin
      apply(!slow, slow, 0, 0, 0, seen);
      if (seen) begin
        total++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic do_kick();
    bit seen;
    apply(0, 0, 1, 0, 0, seen);
  endtask

  task automatic t_reset();
    int first, total;
    check("R1 reset request low", wdt_rst_req, 0);
    run_ticks(16, 0, first, total);
    check("R1 fast tap after reset", first, 16);
    check("R3 one pulse in 16 ticks", total, 1);
    @(negedge clk);
    check("R3 pulse lasts one cycle", wdt_rst_req, 0);
  endtask

  task automatic t_wrap();
    int first, total;
    run_ticks(16, 0, first, total);
    check("R4 restart from zero", first, 16);
  endtask

  task automatic t_slow_ignored();
    int first, total;
    do_kick();
    run_ticks(20, 1, first, total);
    check("R2 slow ticks ignored", total, 0);
    run_ticks(16, 0, first, total);
    check("R2 count untouched by slow", first, 16);
  endtask

  task automatic t_select();
    int first, total;
    bit seen;
    do_kick();
    apply(0, 0, 0, 1, 0, seen);
    run_ticks(20, 0, first, total);
    check("R5 fast ticks ignored when slow", total, 0);
    run_ticks(16, 1, first, total);
    check("R5 slow tap counts", first, 16);
  endtask

  task automatic t_clr_priority();
    int first, total;
    bit seen;
    do_kick();
    apply(0, 0, 0, 1, 1, seen);
    run_ticks(16, 0, first, total);
    check("R6 clear wins over set", first, 16);
  endtask

  task automatic t_kick();
    int first, total;
    bit seen;
    run_ticks(10, 0, first, total);
    do_kick();
    run_ticks(16, 0, first, total);
    check("R7 kick zeroes count", first, 16);
    run_ticks(15, 0, first, total);
    apply(1, 0, 1, 0, 0, seen);
    check("R7 kick with tick no request", seen, 0);
    run_ticks(16, 0, first, total);
    check("R7 kick beats tick", first, 16);
  endtask

  task automatic t_strap();
    int first, total;
    run_ticks(9, 0, first, total);
    @(negedge clk); en_strap = 0;
    run_ticks(40, 0, first, total);
    check("R8 strap off no request", total, 0);
    @(negedge clk); en_strap = 1;
    run_ticks(16, 0, first, total);
    check("R8 restart from zero", first, 16);
  endtask

  task automatic t_midswitch();
    int first, total;
    bit seen;
    do_kick();
    run_ticks(7, 0, first, total);
    apply(1, 0, 0, 1, 0, seen);
    run_ticks(8, 1, first, total);
    check("R9 same-cycle tick uses old tap and count kept", first, 8);
    apply(0, 0, 0, 0, 1, seen);
    run_ticks(16, 0, first, total);
    check("R9 back on fast tap", first, 16);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wrap();
    t_slow_ignored();
    t_select();
    t_clr_priority();
    t_kick();
    t_strap();
    t_midswitch();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule